// File: doc/BRIEF.md
# Crosswalk Traffic Light Sequencer

This block controls the lamps at a crossing of two roads, one running east-west and one north-south. The two directions take turns. A direction is served by a green phase and then a yellow phase, and the other direction shows red for that whole time. After east-west finishes its yellow, north-south goes green, and the cycle then continues in the same alternating order.

Each direction has a pedestrian push button. A press is stored until the next green phase of that direction begins. That green phase then runs for a longer time. For the first part of it, the direction's walk lamp is on. Starting the phase uses up the stored request. A press that arrives during the longer green is kept for the following turn of that direction.

The block does not count clock cycles for its timing. A one-cycle tick input advances all durations. The caller supplies this tick, usually once per second. Every duration is a parameter counted in ticks.

Top module: `crossing_sequencer`

## Requirements
- R1: After reset, east-west shows green (encoding {red,yellow,green} = 3'b001) and north-south shows red (3'b100). Both walk lamps are off, and no pedestrian request is pending.
- R2: In every cycle, each direction drives exactly one of red, yellow and green. While either direction is green or yellow, the other direction is red.
- R3: A green with no pending request lasts GO_TICKS (default 20) ticks. The yellow after any green lasts WARN_TICKS (default 10) ticks.
- R4: Phases run in a fixed order: east-west green, east-west yellow, north-south green, north-south yellow, then east-west green again.
- R5: Lamps change only at a clock edge where tick is high. Cycles without a tick leave every lamp output unchanged, even while buttons are pressed.
- R6: If a request for a direction is pending when that direction's green begins, the green lasts GO_LONG_TICKS (default 30) ticks.
- R7: In an extended green, the direction's walk lamp is on for the first WALK_TICKS (default 10) ticks and off for the rest.
- R8: A button press is stored whatever the current phase is. It is cleared when that direction's green begins, so the next green of that direction has normal length. A press made during the extended green is kept and extends the next green of that direction.
- R9: A walk lamp is lit only while its own direction is green.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse that advances timing by one unit |
| btn_ew | input | 1 | Pedestrian request, east-west |
| btn_ns | input | 1 | Pedestrian request, north-south |
| ew_red | output | 1 | East-west red lamp |
| ew_yellow | output | 1 | East-west yellow lamp |
| ew_green | output | 1 | East-west green lamp |
| ns_red | output | 1 | North-south red lamp |
| ns_yellow | output | 1 | North-south yellow lamp |
| ns_green | output | 1 | North-south green lamp |
| walk_ew | output | 1 | East-west walk lamp |
| walk_ns | output | 1 | North-south walk lamp |

## Verification
When tick is high at an edge, the phase and tick count update at that same edge. The lamps are decoded from those registers without further delay, so a phase change or a walk lamp change is visible in the cycle right after the edge that takes the deciding tick. The bench raises tick at a falling edge, drops it at the next falling edge, and reads the lamps there, after exactly one rising edge.

A button press never changes a lamp directly. Its effect shows up as a longer green with the walk lamp on, at the first green of that direction after the press. The bench therefore counts complete phases of ticks before it checks the result of a request. It also checks the lamps immediately after a press to confirm that nothing moved.

// File: rtl/xw_pkg.sv
package xw_pkg;

    typedef enum logic [1:0] {
        PH_EW_GO   = 2'd0,
        PH_EW_WARN = 2'd1,
        PH_NS_GO   = 2'd2,
        PH_NS_WARN = 2'd3
    } phase_e;

    localparam int DIR_EW  = 0;
    localparam int DIR_NS  = 1;
    localparam int NUM_DIR = 2;

    typedef struct packed {
        logic red;
        logic amber;
        logic go;
        logic walk;
    } lamp_s;

    // Fixed rotation through the four phases.
    function automatic phase_e phase_succ(input phase_e p);
        case (p)
            PH_EW_GO:   return PH_EW_WARN;
            PH_EW_WARN: return PH_NS_GO;
            PH_NS_GO:   return PH_NS_WARN;
            default:    return PH_EW_GO;
        endcase
    endfunction

endpackage

// File: rtl/xw_req_hold.sv
module xw_req_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic press_i,
    input  logic consume_i,
    output logic pending_o
);

    typedef struct packed {
        logic pend;
    } hold_s;

    hold_s st_d, st_q;

    // A press in the same cycle as a consume survives, so it is held over.
    always_comb begin
        st_d      = st_q;
        st_d.pend = press_i | (st_q.pend & ~consume_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending_o = st_q.pend;

endmodule

// File: rtl/xw_phase_timer.sv
module xw_phase_timer
    import xw_pkg::*;
#(
    parameter int GO_TICKS      = 20,
    parameter int GO_LONG_TICKS = 30,
    parameter int WARN_TICKS    = 10,
    parameter int CNT_W         = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_i,
    input  logic [NUM_DIR-1:0] pending_i,
    output phase_e             phase_o,
    output logic [CNT_W-1:0]   count_o,
    output logic               long_o,
    output logic [NUM_DIR-1:0] consume_o
);

    typedef struct packed {
        phase_e             phase;
        logic [CNT_W-1:0]   cnt;
        logic               long_go;
    } tmr_s;

    tmr_s st_d, st_q;

    logic [CNT_W-1:0] last_cnt;
    logic             at_last;
    phase_e           upcoming;

    always_comb begin
        case (st_q.phase)
            PH_EW_GO, PH_NS_GO:
                last_cnt = st_q.long_go ? CNT_W'(GO_LONG_TICKS - 1) : CNT_W'(GO_TICKS - 1);
            default:
                last_cnt = CNT_W'(WARN_TICKS - 1);
        endcase
        at_last  = (st_q.cnt == last_cnt);
        upcoming = phase_succ(st_q.phase);
    end

    always_comb begin
        st_d      = st_q;
        consume_o = '0;
        if (tick_i) begin
            if (at_last) begin
                st_d.cnt   = '0;
                st_d.phase = upcoming;
                if (upcoming == PH_EW_GO) begin
                    st_d.long_go      = pending_i[DIR_EW];
                    consume_o[DIR_EW] = 1'b1;
                end else if (upcoming == PH_NS_GO) begin
                    st_d.long_go      = pending_i[DIR_NS];
                    consume_o[DIR_NS] = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase   <= PH_EW_GO;
            st_q.cnt     <= '0;
            st_q.long_go <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.phase;
    assign count_o = st_q.cnt;
    assign long_o  = st_q.long_go;

endmodule

// File: rtl/xw_lamp_dec.sv
module xw_lamp_dec
    import xw_pkg::*;
#(
    parameter int WALK_TICKS = 10,
    parameter int CNT_W      = 5
) (
    input  phase_e           phase_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic             long_i,
    output lamp_s            lamps_o [NUM_DIR]
);

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        localparam phase_e GO_PH   = (d == DIR_EW) ? PH_EW_GO   : PH_NS_GO;
        localparam phase_e WARN_PH = (d == DIR_EW) ? PH_EW_WARN : PH_NS_WARN;

        logic is_go, is_warn;

        always_comb begin
            is_go              = (phase_i == GO_PH);
            is_warn            = (phase_i == WARN_PH);
            lamps_o[d].go      = is_go;
            lamps_o[d].amber   = is_warn;
            lamps_o[d].red     = ~(is_go | is_warn);
            lamps_o[d].walk    = is_go & long_i & (count_i < CNT_W'(WALK_TICKS));
        end
    end

endmodule

// File: rtl/crossing_sequencer.sv
module crossing_sequencer
    import xw_pkg::*;
#(
    parameter int GO_TICKS      = 20,
    parameter int GO_LONG_TICKS = 30,
    parameter int WARN_TICKS    = 10,
    parameter int WALK_TICKS    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic btn_ew,
    input  logic btn_ns,
    output logic ew_red,
    output logic ew_yellow,
    output logic ew_green,
    output logic ns_red,
    output logic ns_yellow,
    output logic ns_green,
    output logic walk_ew,
    output logic walk_ns
);

    localparam int MAX_A   = (GO_TICKS > GO_LONG_TICKS) ? GO_TICKS : GO_LONG_TICKS;
    localparam int MAX_DUR = (MAX_A > WARN_TICKS) ? MAX_A : WARN_TICKS;
    localparam int CNT_W   = $clog2(MAX_DUR + 1);

    logic [NUM_DIR-1:0] press_w;
    logic [NUM_DIR-1:0] pending_w;
    logic [NUM_DIR-1:0] consume_w;
    phase_e             phase_w;
    logic [CNT_W-1:0]   count_w;
    logic               long_w;
    lamp_s              lamps_w [NUM_DIR];

    assign press_w[DIR_EW] = btn_ew;
    assign press_w[DIR_NS] = btn_ns;

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_req
        xw_req_hold i_hold (
            .clk       (clk),
            .rst_n     (rst_n),
            .press_i   (press_w[d]),
            .consume_i (consume_w[d]),
            .pending_o (pending_w[d])
        );
    end

    xw_phase_timer #(
        .GO_TICKS      (GO_TICKS),
        .GO_LONG_TICKS (GO_LONG_TICKS),
        .WARN_TICKS    (WARN_TICKS),
        .CNT_W         (CNT_W)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick),
        .pending_i (pending_w),
        .phase_o   (phase_w),
        .count_o   (count_w),
        .long_o    (long_w),
        .consume_o (consume_w)
    );

    xw_lamp_dec #(
        .WALK_TICKS (WALK_TICKS),
        .CNT_W      (CNT_W)
    ) i_dec (
        .phase_i (phase_w),
        .count_i (count_w),
        .long_i  (long_w),
        .lamps_o (lamps_w)
    );

    assign ew_red    = lamps_w[DIR_EW].red;
    assign ew_yellow = lamps_w[DIR_EW].amber;
    assign ew_green  = lamps_w[DIR_EW].go;
    assign walk_ew   = lamps_w[DIR_EW].walk;
    assign ns_red    = lamps_w[DIR_NS].red;
    assign ns_yellow = lamps_w[DIR_NS].amber;
    assign ns_green  = lamps_w[DIR_NS].go;
    assign walk_ns   = lamps_w[DIR_NS].walk;

endmodule

// File: rtl/xw_seq_chk.sv
module xw_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic ew_red,
    input logic ew_yellow,
    input logic ew_green,
    input logic ns_red,
    input logic ns_yellow,
    input logic ns_green,
    input logic walk_ew,
    input logic walk_ns
);

    // R2
    ew_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ew_red, ew_yellow, ew_green}) == 1);

    // R2
    ns_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ns_red, ns_yellow, ns_green}) == 1);

    // R2
    cross_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ew_green | ew_yellow) |-> ns_red);

    // R4
    ew_to_ns_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ew_yellow) |-> ns_green);

    // R4
    ns_to_ew_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ns_yellow) |-> ew_green);

    // R5
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable({ew_red, ew_yellow, ew_green, ns_red, ns_yellow,
                           ns_green, walk_ew, walk_ns}));

    // R9
    walk_ew_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_ew |-> ew_green);

    // R9
    walk_ns_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        walk_ns |-> ns_green);

    // R7
    walk_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(walk_ns) |-> $rose(ns_green));

endmodule

bind crossing_sequencer xw_seq_chk i_seq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .ew_red    (ew_red),
    .ew_yellow (ew_yellow),
    .ew_green  (ew_green),
    .ns_red    (ns_red),
    .ns_yellow (ns_yellow),
    .ns_green  (ns_green),
    .walk_ew   (walk_ew),
    .walk_ns   (walk_ns)
);

// File: tb/test_crossing_sequencer.sv
module test_crossing_sequencer;

    localparam logic [2:0] RED = 3'b100;
    localparam logic [2:0] AMB = 3'b010;
    localparam logic [2:0] GRN = 3'b001;

    logic clk = 1'b0;
    logic rst_n, tick, btn_ew, btn_ns;
    logic ew_red, ew_yellow, ew_green, ns_red, ns_yellow, ns_green;
    logic walk_ew, walk_ns;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    crossing_sequencer i_crossing_sequencer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .btn_ew    (btn_ew),
        .btn_ns    (btn_ns),
        .ew_red    (ew_red),
        .ew_yellow (ew_yellow),
        .ew_green  (ew_green),
        .ns_red    (ns_red),
        .ns_yellow (ns_yellow),
        .ns_green  (ns_green),
        .walk_ew   (walk_ew),
        .walk_ns   (walk_ns)
    );

    task automatic chk(input string tag, input logic [2:0] ew, input logic [2:0] ns,
                       input logic we, input logic wn);
        n_tests++;
        if ({ew_red, ew_yellow, ew_green} !== ew || {ns_red, ns_yellow, ns_green} !== ns
            || walk_ew !== we || walk_ns !== wn) begin
            n_fail++;
            $display("FAIL %s: ew=%b ns=%b walk=%b%b expected ew=%b ns=%b walk=%b%b",
                     tag, {ew_red, ew_yellow, ew_green}, {ns_red, ns_yellow, ns_green},
                     walk_ew, walk_ns, ew, ns, we, wn);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
        end
    endtask

    task automatic press(input bit ns_dir);
        @(negedge clk);
        if (ns_dir) btn_ns = 1'b1; else btn_ew = 1'b1;
        @(negedge clk);
        btn_ns = 1'b0;
        btn_ew = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 reset state", GRN, RED, 1'b0, 1'b0);
    endtask

    task automatic t_normal_cycle();
        ticks(19); chk("R3 EW green before 20 ticks", GRN, RED, 1'b0, 1'b0);
        ticks(1);  chk("R3 EW yellow after 20 ticks", AMB, RED, 1'b0, 1'b0);
        ticks(9);  chk("R3 EW yellow before 10 ticks", AMB, RED, 1'b0, 1'b0);
        ticks(1);  chk("R4 NS green after EW yellow", RED, GRN, 1'b0, 1'b0);
        ticks(19); chk("R3 NS green before 20 ticks", RED, GRN, 1'b0, 1'b0);
        ticks(1);  chk("R4 NS yellow after NS green", RED, AMB, 1'b0, 1'b0);
        ticks(10); chk("R4 EW green after NS yellow", GRN, RED, 1'b0, 1'b0);
    endtask

    task automatic t_no_tick();
        ticks(19);
        btn_ew = 1'b0;
        repeat (40) @(negedge clk);
        chk("R5 idle cycles keep EW green", GRN, RED, 1'b0, 1'b0);
        ticks(1);  chk("R5 count resumes to yellow", AMB, RED, 1'b0, 1'b0);
        ticks(40); chk("R4 full turn back to EW green", GRN, RED, 1'b0, 1'b0);
    endtask

    task automatic t_ped_ns();
        press(1'b1);
        chk("R8 press alone changes no lamp", GRN, RED, 1'b0, 1'b0);
        ticks(20); chk("R3 EW yellow with NS pending", AMB, RED, 1'b0, 1'b0);
        ticks(10); chk("R7 NS walk on at green start", RED, GRN, 1'b0, 1'b1);
        ticks(9);  chk("R7 NS walk still on", RED, GRN, 1'b0, 1'b1);
        ticks(1);  chk("R7 NS walk off after 10 ticks", RED, GRN, 1'b0, 1'b0);
        ticks(19); chk("R6 NS green still on at 29 ticks", RED, GRN, 1'b0, 1'b0);
        ticks(1);  chk("R6 NS yellow after 30 ticks", RED, AMB, 1'b0, 1'b0);
        ticks(10); chk("R9 EW green without walk", GRN, RED, 1'b0, 1'b0);
    endtask

    task automatic t_consumed();
        ticks(30); chk("R8 NS green not extended again", RED, GRN, 1'b0, 1'b0);
        ticks(19); chk("R8 NS green at 19 ticks", RED, GRN, 1'b0, 1'b0);
        ticks(1);  chk("R8 NS yellow after 20 ticks", RED, AMB, 1'b0, 1'b0);
        ticks(10); chk("R4 EW green", GRN, RED, 1'b0, 1'b0);
    endtask

    task automatic t_held();
        press(1'b0);
        ticks(60); chk("R6 EW walk on at served green", GRN, RED, 1'b1, 1'b0);
        ticks(5);
        press(1'b0);
        chk("R7 EW walk still on after press", GRN, RED, 1'b1, 1'b0);
        ticks(25); chk("R6 EW yellow after 30 ticks", AMB, RED, 1'b0, 1'b0);
        ticks(40); chk("R8 held press serves next EW green", GRN, RED, 1'b1, 1'b0);
        ticks(10); chk("R7 EW walk off after 10 ticks", GRN, RED, 1'b0, 1'b0);
        ticks(20); chk("R6 second extended EW green ends", AMB, RED, 1'b0, 1'b0);
    endtask

    initial begin
        rst_n  = 1'b0;
        tick   = 1'b0;
        btn_ew = 1'b0;
        btn_ns = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal_cycle();
        t_no_tick();
        t_ped_ns();
        t_consumed();
        t_held();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule